// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Register Unit

This unit holds the part of a flash controller's host register file that tells software whether the controller is busy and what went wrong. It contains four registers. The interrupt register carries a master completion flag and per-operation done flags. The status register carries per-operation error flags. Two configuration words set the interrupt polarity and drive the ready line. A fifth location latches host commands and passes them to the operation engine.

The host accesses the unit one 16-bit word at a time, selected by register offset. Write data is captured on the clock edge, and read data is returned combinationally for the current offset. The operation engine reports a finished operation as a single-cycle pulse on the done and error vectors. Software acknowledges an operation by AND-writing the interrupt register. Clearing the master flag also wipes the error flags. While the master flag stays set, command writes are refused.

Top module: `flash_irq_regs`

## Requirements
- R1: After the asynchronous reset, reads return 0x40C0 for config-1, 0x0000 for config-2, 0x8080 for interrupt, 0x0000 for status and 0x0000 for command. Also after this reset, irq_o=1, rdy_o=1 and cmd_valid_o=0.
- R2: When warm_rst_i is high at a clock edge, the registers take these values at that edge: interrupt 0x8010, config-1 0x40C0, config-2 0, status 0, command 0. This has priority over host writes and events in the same cycle.
- R3: A host write to offset 0xF241 replaces the interrupt register with its old value AND the written word.
- R4: If that AND leaves bit 15 clear, status bits 10 to 13 are cleared at the same edge. If bit 15 remains set, the status flags are kept.
- R5: In the cycle an event pulse arrives, done_i bits 0, 1, 2 and 3 (reset, erase, program, load) are ORed into interrupt bits 4, 5, 6 and 7. If any done or error bit is set, interrupt bit 15 is also set. The result is readable after that edge.
- R6: In that same cycle, err_i bits 0, 1, 2 and 3 (command, erase, program, load) are ORed into status bits 10, 11, 12 and 13.
- R7: irq_o equals interrupt bit 15 XOR NOT config-1 bit 6.
- R8: rdy_o equals bit 7 of the last value written to config-1 (offset 0xF221), or of its reset value.
- R9: A read of config-1 returns the stored word AND 0xFFE0. Config-2 (offset 0xF222) stores and returns all 16 bits.
- R10: A write to offset 0xF220 while interrupt bit 15 is set is dropped: no pulse is issued and the readback is unchanged. Otherwise the word is latched, and cmd_o carries it with cmd_valid_o high for exactly the one cycle after the write edge.
- R11: Reads of any offset other than 0xF220, 0xF221, 0xF222, 0xF240 and 0xF241 return zero. Status at 0xF240 is read-only.
- R12: When an interrupt write and an event fall in the same cycle, the AND (with its error clear) is applied first, and the event bits are ORed on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | Synchronous warm/hot reset request |
| we_i | input | 1 | Host write strobe |
| addr_i | input | 16 | Host register offset |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| done_i | input | 4 | Completion pulse: reset, erase, program, load |
| err_i | input | 4 | Error pulse: command, erase, program, load |
| cmd_o | output | 16 | Latched command word |
| cmd_valid_o | output | 1 | One-cycle command issue pulse |
| irq_o | output | 1 | Interrupt line, polarity from config-1 bit 6 |
| rdy_o | output | 1 | Ready line from config-1 bit 7 |

## Verification
The hardest case to reach is an acknowledgement write to the interrupt register landing in the same clock as a new completion event. In that case the error clear and the fresh error set compete for the status bits. The bench first loads every done and error flag through an event. It then drives the bus write and the event pulse in the same cycle and checks that only the new flags survive. The same preload-then-mask approach is swept over all 32 AND patterns of the master and done bits. Command gating is reached by leaving the reset-time master flag set and then setting it again with an event after a successful issue.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int unsigned DW       = 16;
  localparam int unsigned N_EVT    = 4;
  localparam int unsigned MST_BIT  = 15;
  localparam int unsigned DONE_LSB = 4;
  localparam int unsigned ERR_LSB  = 10;
  localparam int unsigned POL_BIT  = 6;
  localparam int unsigned RDY_BIT  = 7;

  typedef logic [DW-1:0] word_t;

  localparam word_t CFG1_RST     = 16'h40C0;
  localparam word_t CFG2_RST     = 16'h0000;
  localparam word_t INT_COLD_RST = 16'h8080;
  localparam word_t INT_WARM_RST = 16'h8010;
  localparam word_t CFG1_RD_MASK = 16'hFFE0;
endpackage

// File: rtl/flash_irq_cfg.sv
module flash_irq_cfg
  import flash_irq_pkg::*;
#(
  parameter word_t C1_RST  = CFG1_RST,
  parameter word_t C2_RST  = CFG2_RST,
  parameter word_t RD_MASK = CFG1_RD_MASK
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  warm_i,
  input  logic  wr1_i,
  input  logic  wr2_i,
  input  word_t wdata_i,
  output word_t cfg1_o,
  output word_t cfg1_rd_o,
  output word_t cfg2_o
);
  word_t cfg1_q, cfg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= C1_RST;
      cfg2_q <= C2_RST;
    end else if (warm_i) begin
      cfg1_q <= C1_RST;
      cfg2_q <= C2_RST;
    end else begin
      if (wr1_i) cfg1_q <= wdata_i;
      if (wr2_i) cfg2_q <= wdata_i;
    end
  end

  assign cfg1_o    = cfg1_q;
  assign cfg1_rd_o = cfg1_q & RD_MASK;
  assign cfg2_o    = cfg2_q;
endmodule

// File: rtl/flash_irq_stat.sv
module flash_irq_stat
  import flash_irq_pkg::*;
#(
  parameter int unsigned NE = N_EVT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_i,
  input  logic          int_we_i,
  input  word_t         wdata_i,
  input  logic [NE-1:0] done_i,
  input  logic [NE-1:0] err_i,
  output word_t         int_o,
  output word_t         status_o
);
  localparam logic [NE-1:0] ZERO_EVT = '0;

  word_t int_q, st_q;
  word_t done_w, err_w, err_mask;
  word_t int_and, int_nxt, st_keep, st_nxt;

  // place event bits at their register positions
  for (genvar i = 0; i < DW; i++) begin : g_map
    if (i >= DONE_LSB && i < DONE_LSB + NE) begin : g_done
      assign done_w[i] = done_i[i-DONE_LSB];
    end else begin : g_done0
      assign done_w[i] = 1'b0;
    end
    if (i >= ERR_LSB && i < ERR_LSB + NE) begin : g_err
      assign err_w[i]    = err_i[i-ERR_LSB];
      assign err_mask[i] = 1'b1;
    end else begin : g_err0
      assign err_w[i]    = 1'b0;
      assign err_mask[i] = 1'b0;
    end
  end

  always_comb begin
    int_and = int_we_i ? (int_q & wdata_i) : int_q;
    st_keep = (int_we_i && !int_and[MST_BIT]) ? (st_q & ~err_mask) : st_q;
    int_nxt = int_and | done_w;
    if ((done_i != ZERO_EVT) || (err_i != ZERO_EVT)) int_nxt[MST_BIT] = 1'b1;
    st_nxt  = st_keep | err_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= INT_COLD_RST;
      st_q  <= '0;
    end else if (warm_i) begin
      int_q <= INT_WARM_RST;
      st_q  <= '0;
    end else begin
      int_q <= int_nxt;
      st_q  <= st_nxt;
    end
  end

  assign int_o    = int_q;
  assign status_o = st_q;
endmodule

// File: rtl/flash_irq_cmd.sv
module flash_irq_cmd
  import flash_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  warm_i,
  input  logic  cmd_we_i,
  input  logic  busy_i,
  input  word_t wdata_i,
  output word_t cmd_o,
  output logic  cmd_valid_o
);
  word_t cmd_q;
  logic  vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      vld_q <= 1'b0;
    end else if (warm_i) begin
      cmd_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= cmd_we_i && !busy_i;
      if (cmd_we_i && !busy_i) cmd_q <= wdata_i;
    end
  end

  assign cmd_o       = cmd_q;
  assign cmd_valid_o = vld_q;
endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
  import flash_irq_pkg::*;
#(
  parameter logic [15:0] CMD_OFS  = 16'hF220,
  parameter logic [15:0] CFG1_OFS = 16'hF221,
  parameter logic [15:0] CFG2_OFS = 16'hF222,
  parameter logic [15:0] STAT_OFS = 16'hF240,
  parameter logic [15:0] INT_OFS  = 16'hF241
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        warm_rst_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic [3:0]  done_i,
  input  logic [3:0]  err_i,
  output logic [15:0] cmd_o,
  output logic        cmd_valid_o,
  output logic        irq_o,
  output logic        rdy_o
);
  word_t cfg1_q, cfg1_rd, cfg2_q, int_q, status_q;

  flash_irq_cfg u_cfg (
    .clk_i, .rst_ni, .warm_i(warm_rst_i),
    .wr1_i(we_i && addr_i == CFG1_OFS),
    .wr2_i(we_i && addr_i == CFG2_OFS),
    .wdata_i, .cfg1_o(cfg1_q), .cfg1_rd_o(cfg1_rd), .cfg2_o(cfg2_q)
  );

  flash_irq_stat u_stat (
    .clk_i, .rst_ni, .warm_i(warm_rst_i),
    .int_we_i(we_i && addr_i == INT_OFS),
    .wdata_i, .done_i, .err_i, .int_o(int_q), .status_o(status_q)
  );

  flash_irq_cmd u_cmd (
    .clk_i, .rst_ni, .warm_i(warm_rst_i),
    .cmd_we_i(we_i && addr_i == CMD_OFS),
    .busy_i(int_q[MST_BIT]),
    .wdata_i, .cmd_o, .cmd_valid_o
  );

  always_comb begin
    unique case (addr_i)
      CMD_OFS:  rdata_o = cmd_o;
      CFG1_OFS: rdata_o = cfg1_rd;
      CFG2_OFS: rdata_o = cfg2_q;
      STAT_OFS: rdata_o = status_q;
      INT_OFS:  rdata_o = int_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = int_q[MST_BIT] ^ ~cfg1_q[POL_BIT];
  assign rdy_o = cfg1_q[RDY_BIT];
endmodule

// File: rtl/flash_irq_regs_chk.sv
module flash_irq_regs_chk #(
  parameter logic [15:0] CMD_OFS  = 16'hF220,
  parameter logic [15:0] CFG1_OFS = 16'hF221,
  parameter logic [15:0] INT_OFS  = 16'hF241
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        warm_rst_i,
  input logic        we_i,
  input logic [15:0] addr_i,
  input logic [15:0] wdata_i,
  input logic [3:0]  done_i,
  input logic [3:0]  err_i,
  input logic [15:0] int_q,
  input logic [15:0] status_q,
  input logic [15:0] cmd_o,
  input logic        cmd_valid_o,
  input logic        rdy_o
);
  // R2
  warm_vals_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> (int_q == 16'h8010) && (status_q == 16'h0000));

  // R4
  err_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == INT_OFS && !wdata_i[15] && err_i == 4'h0 && !warm_rst_i)
      |=> status_q[13:10] == 4'h0);

  // R5
  master_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_i != 4'h0 || err_i != 4'h0) && !warm_rst_i) |=> int_q[15]);

  // R8
  rdy_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CFG1_OFS && !warm_rst_i) |=> rdy_o == $past(wdata_i[7]));

  // R10
  cmd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CMD_OFS && int_q[15]) |=> !cmd_valid_o);

  // R10
  cmd_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CMD_OFS && !int_q[15] && !warm_rst_i)
      |=> cmd_valid_o && cmd_o == $past(wdata_i));

  // R10
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> $stable(cmd_o) || cmd_valid_o);
endmodule

bind flash_irq_regs flash_irq_regs_chk #(
  .CMD_OFS(CMD_OFS), .CFG1_OFS(CFG1_OFS), .INT_OFS(INT_OFS)
) u_chk (
  .clk_i, .rst_ni, .warm_rst_i, .we_i, .addr_i, .wdata_i, .done_i, .err_i,
  .int_q, .status_q, .cmd_o, .cmd_valid_o, .rdy_o
);

// File: tb/sim_flash_irq_regs.sv
`timescale 1ns/1ps
module sim_flash_irq_regs;
  logic clk = 1'b0, rst_ni = 1'b0, warm = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0, rdata, cmd;
  logic [3:0] done = '0, err = '0;
  logic cmd_valid, irq, rdy;
  int nvec = 0, nbad = 0;

  localparam logic [15:0] A_CMD = 16'hF220, A_C1 = 16'hF221, A_C2 = 16'hF222,
                          A_ST = 16'hF240, A_INT = 16'hF241;

  always #4 clk = ~clk;

  flash_irq_regs u0 (
    .clk_i(clk), .rst_ni, .warm_rst_i(warm), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_i(done), .err_i(err),
    .cmd_o(cmd), .cmd_valid_o(cmd_valid), .irq_o(irq), .rdy_o(rdy)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic evt(logic [3:0] dn, logic [3:0] er);
    @(negedge clk); done = dn; err = er;
    @(negedge clk); done = '0; err = '0;
  endtask

  task automatic chk_rd(string req, logic [15:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [15:0] exp_i, exp_s, m, v;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    // R1
    chk_rd("R1 cfg1", A_C1, 16'h40C0);
    chk_rd("R1 cfg2", A_C2, 16'h0000);
    chk_rd("R1 int", A_INT, 16'h8080);
    chk_rd("R1 status", A_ST, 16'h0000);
    chk_rd("R1 cmd", A_CMD, 16'h0000);
    chk("R1 irq/rdy/vld", {13'd0, irq, rdy, cmd_valid}, 16'h0006);

    // R11 sweep of unmapped offsets
    for (int a = 16'hF200; a < 16'hF300; a++) begin
      if (a != A_CMD && a != A_C1 && a != A_C2 && a != A_ST && a != A_INT)
        chk_rd("R11 unmapped", 16'(a), 16'h0000);
    end
    chk_rd("R11 low", 16'h0000, 16'h0000);
    chk_rd("R11 high", 16'hFFFF, 16'h0000);
    wr(A_ST, 16'hFFFF);
    chk_rd("R11 status read-only", A_ST, 16'h0000);

    // R10 gated at reset (master bit set)
    wr(A_CMD, 16'h0094);
    chk("R10 gated pulse", {15'd0, cmd_valid}, 16'h0);
    chk_rd("R10 gated readback", A_CMD, 16'h0000);

    // R3 R4 AND-write sweep
    for (int k = 0; k < 32; k++) begin
      wr(A_INT, 16'h0000);
      evt(4'hF, 4'hF);
      m = {k[4], 7'h7F, k[3:0], 4'hF};
      wr(A_INT, m);
      chk_rd("R3 and-write", A_INT, 16'h80F0 & m);
      chk_rd("R4 err wipe", A_ST, k[4] ? 16'h3C00 : 16'h0000);
    end

    // R5 R6 event sweep
    for (int d = 0; d < 16; d++) begin
      for (int e = 0; e < 16; e++) begin
        wr(A_INT, 16'h0000);
        evt(d[3:0], e[3:0]);
        exp_i = {(d != 0 || e != 0), 7'd0, d[3:0], 4'd0};
        exp_s = {2'd0, e[3:0], 10'd0};
        chk_rd("R5 done bits", A_INT, exp_i);
        chk_rd("R6 err bits", A_ST, exp_s);
      end
    end

    // R7 R8 R9 polarity, ready and mask
    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < 2; b++) begin
        wr(A_INT, 16'h0000);
        if (b == 1) evt(4'h1, 4'h0);
        v = 16'hA51F | {8'd0, c[1], c[0], 6'd0};
        wr(A_C1, v);
        @(negedge clk);
        chk("R7 irq", {15'd0, irq}, {15'd0, 1'(b) ^ ~c[0]});
        chk("R8 rdy", {15'd0, rdy}, {15'd0, c[1]});
        chk_rd("R9 cfg1 mask", A_C1, v & 16'hFFE0);
      end
    end
    wr(A_C2, 16'hBEEF);
    chk_rd("R9 cfg2", A_C2, 16'hBEEF);

    // R10 issue and re-gate
    wr(A_INT, 16'h0000);
    wr(A_CMD, 16'h0094);
    chk("R10 pulse", {15'd0, cmd_valid}, 16'h1);
    chk("R10 cmd_o", cmd, 16'h0094);
    @(negedge clk);
    chk("R10 pulse width", {15'd0, cmd_valid}, 16'h0);
    chk_rd("R10 readback", A_CMD, 16'h0094);
    evt(4'h2, 4'h0);
    wr(A_CMD, 16'h0023);
    chk("R10 regate pulse", {15'd0, cmd_valid}, 16'h0);
    chk_rd("R10 regate readback", A_CMD, 16'h0094);

    // R12 ack and event in one cycle
    wr(A_INT, 16'h0000);
    evt(4'hF, 4'hF);
    @(negedge clk);
    we = 1'b1; addr = A_INT; wdata = 16'h0000; done = 4'h8; err = 4'h8;
    @(negedge clk);
    we = 1'b0; done = '0; err = '0;
    chk_rd("R12 int", A_INT, 16'h8080);
    chk_rd("R12 status", A_ST, 16'h2000);

    // R2 warm reset
    wr(A_C1, 16'h0000);
    evt(4'h0, 4'h5);
    @(negedge clk); warm = 1'b1; we = 1'b1; addr = A_C2; wdata = 16'h1234;
    @(negedge clk); warm = 1'b0; we = 1'b0;
    chk_rd("R2 int", A_INT, 16'h8010);
    chk_rd("R2 cfg1", A_C1, 16'h40C0);
    chk_rd("R2 cfg2", A_C2, 16'h0000);
    chk_rd("R2 status", A_ST, 16'h0000);
    chk_rd("R2 cmd", A_CMD, 16'h0000);
    chk("R2 rdy", {15'd0, rdy}, 16'h1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule